// File: doc/BRIEF.md
# SD Data FIFO Byte Packer

This block is the data path of an SD host controller. On one side a 32-bit host register port gives word access to a 16-entry FIFO and to the registers that set up a transfer. On the other side are two byte-wide streams with valid/ready handshakes: one from the card and one to the card. A transfer starts when the host writes the block-count register. The engine then moves block size × block count bytes, at most one byte per clock. The command register chooses the direction.

In the card-to-host direction, incoming bytes are packed little-endian into words and pushed into the FIFO. If the transfer ends part way through a word, that word is zero-padded. In the host-to-card direction, words are popped from the FIFO and sent to the card least significant byte first.

Sticky status flags report word movement and the end of a write. The status flags clear when the host writes ones to them. A read-only debug register shows the current FIFO fill level and a state field that switches to data mode when the byte counter reaches zero.

Top module: `sdfp_top`

## Requirements
- R1: The FIFO holds 16 words of 32 bits in ring order. A push while it holds 16 words is dropped. A pop while it is empty returns 0.
- R2: Block size is at offset 0x3C and block count at offset 0x50. Both read back as written (16 bits). Writing block count loads the byte counter with block count × block size.
- R3: The command register is at offset 0x00 (16 bits, bit 15 reads back as 0). Command bit 6 set selects card-to-host. A card byte is accepted (card_rx_ready high) only while the counter is non-zero, the FIFO is not full and card_rx_valid is high. The first byte of a word lands in bits 7:0 and the fourth in bits 31:24.
- R4: Each full word pushed in the card-to-host direction sets status bit 0. It also sets status bit 8 if configuration bit 4 is set. Configuration is at offset 0x38 and status at offset 0x20.
- R5: When the counter reaches zero with 1 to 3 bytes of a word collected, that word is pushed with its upper bytes zero. This push sets status bit 0 only.
- R6: Command bit 7 set with bit 6 clear selects host-to-card. Each word popped sets status bit 0, and also status bit 8 when configuration bit 4 is set. Its bytes go out on card_tx_data least significant first, and no byte is sent once the counter is zero.
- R7: When the counter reaches zero, debug register (offset 0x34) bits 3:0 become 1 and xfer_done pulses for one cycle. Status bit 9 is set if command bit 7 and configuration bit 8 are both set.
- R8: Debug register bits 8:4 always equal the FIFO fill level.
- R9: Writing the status register clears each flag whose bit is 1 in the written value. Other flags are kept.
- R10: Reading offset 0x40 returns the FIFO head and pops it. Writing offset 0x40 pushes the written word.
- R11: After reset the counter is zero, the FIFO is empty, and the status and debug registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe (pops on the data offset) |
| reg_addr | input | 8 | Host register byte offset |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data, combinational on reg_addr |
| card_rx_data | input | 8 | Byte from the card |
| card_rx_valid | input | 1 | Card byte available |
| card_rx_ready | output | 1 | Block takes the card byte at this edge |
| card_tx_data | output | 8 | Byte to the card |
| card_tx_valid | output | 1 | Byte to the card available |
| card_tx_ready | input | 1 | Card takes the byte at this edge |
| xfer_done | output | 1 | One-cycle pulse after the counter reaches zero |

## Verification
If the write pointer, read pointer or fill count is wrong, the next data-register read returns the wrong word. The debug fill field also differs right away, as soon as that state has moved. If the pack index is wrong, bytes are placed in the wrong position, and this is visible on the first word read back after a read transfer. If the counter is off by one, a write transfer sends a byte too many or too few. The same error moves the xfer_done pulse and the change of the debug state field by a cycle.

// File: rtl/sdfp_pkg.sv
package sdfp_pkg;
  localparam logic [7:0] OFS_CMD   = 8'h00;
  localparam logic [7:0] OFS_STAT  = 8'h20;
  localparam logic [7:0] OFS_DBG   = 8'h34;
  localparam logic [7:0] OFS_CFG   = 8'h38;
  localparam logic [7:0] OFS_BSZ   = 8'h3C;
  localparam logic [7:0] OFS_DATA  = 8'h40;
  localparam logic [7:0] OFS_BCNT  = 8'h50;

  localparam int CMD_RD_BIT     = 6;
  localparam int CMD_WR_BIT     = 7;
  localparam int CMD_LAUNCH_BIT = 15;
  localparam int CFG_DINT_BIT   = 4;
  localparam int CFG_BINT_BIT   = 8;

  localparam logic [3:0] FSM_IDLE = 4'd0;
  localparam logic [3:0] FSM_DATA = 4'd1;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_RD   = 2'd1,
    MODE_WR   = 2'd2
  } xfer_mode_e;
endpackage

// File: rtl/sdfp_fifo.sv
module sdfp_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int LW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic          do_push, do_pop;

  always_comb begin
    full    = (lvl_q == LW'(DEPTH));
    empty   = (lvl_q == '0);
    do_push = push && !full;
    do_pop  = pop && !empty;
    wp_d    = do_push ? wp_q + PW'(1) : wp_q;
    rp_d    = do_pop  ? rp_q + PW'(1) : rp_q;
    lvl_d   = lvl_q + LW'(do_push) - LW'(do_pop);
    head    = empty ? '0 : mem[rp_q];
    level   = lvl_q;
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      lvl_q <= lvl_d;
    end
  end

  // R1: fill level never exceeds the depth
  a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LW'(DEPTH));
  // R1: a push into a full FIFO without a pop leaves it full
  a_r1_drop_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (lvl_q == LW'(DEPTH)));
endmodule

// File: rtl/sdfp_engine.sv
module sdfp_engine
  import sdfp_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  xfer_mode_e       mode,
  input  logic             cmd_wr,
  input  logic             dint_en,
  input  logic             bint_en,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             host_push,
  input  logic             host_pop,
  input  logic             fifo_full,
  input  logic             fifo_empty,
  input  logic [31:0]      fifo_head,
  input  logic [7:0]       rx_data,
  input  logic             rx_valid,
  output logic             rx_ready,
  output logic [7:0]       tx_data,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic             eng_push,
  output logic [31:0]      eng_push_data,
  output logic             eng_pop,
  output logic             ev_data,
  output logic             ev_sdio,
  output logic             ev_block,
  output logic             ev_done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [31:0]      pack_q, pack_d, merged;
  logic [1:0]       idx_q, idx_d;
  logic [31:0]      tx_q, tx_d;
  logic [2:0]       left_q, left_d;
  logic             cnt_nz, rx_fire, tx_fire;

  always_comb begin
    cnt_nz   = (cnt_q != '0);
    rx_ready = (mode == MODE_RD) && cnt_nz && !fifo_full && !host_push && !load;
    rx_fire  = rx_ready && rx_valid;
    merged   = pack_q;
    merged[idx_q*8 +: 8] = rx_data;
    eng_push      = rx_fire && ((idx_q == 2'd3) || (cnt_q == CNT_W'(1)));
    eng_push_data = merged;

    tx_valid = (mode == MODE_WR) && cnt_nz && (left_q != 3'd0) && !load;
    tx_fire  = tx_valid && tx_ready;
    tx_data  = tx_q[7:0];
    eng_pop  = (mode == MODE_WR) && cnt_nz && (left_q == 3'd0) && !fifo_empty
               && !host_pop && !load;

    ev_data  = eng_push || eng_pop;
    ev_sdio  = dint_en && ((eng_push && (idx_q == 2'd3)) || eng_pop);
    ev_done  = (rx_fire || tx_fire) && (cnt_q == CNT_W'(1));
    ev_block = ev_done && cmd_wr && bint_en;

    cnt_d  = cnt_q;
    pack_d = pack_q;
    idx_d  = idx_q;
    tx_d   = tx_q;
    left_d = left_q;
    if (load) begin
      cnt_d  = load_val;
      pack_d = '0;
      idx_d  = '0;
      left_d = '0;
    end else begin
      if (rx_fire) begin
        cnt_d = cnt_q - CNT_W'(1);
        if (eng_push) begin
          pack_d = '0;
          idx_d  = '0;
        end else begin
          pack_d = merged;
          idx_d  = idx_q + 2'd1;
        end
      end
      if (eng_pop) begin
        tx_d   = fifo_head;
        left_d = 3'd4;
      end else if (tx_fire) begin
        tx_d   = tx_q >> 8;
        left_d = left_q - 3'd1;
        cnt_d  = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pack_q <= '0;
      idx_q  <= '0;
      tx_q   <= '0;
      left_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      pack_q <= pack_d;
      idx_q  <= idx_d;
      tx_q   <= tx_d;
      left_q <= left_d;
    end
  end

  // R2: a load lands the product in the counter
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));
  // R3: each accepted card byte takes exactly one count
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fire || tx_fire) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  // R5: a partial word never carries a top byte
  a_r5_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_push && (idx_q != 2'd3)) |-> (eng_push_data[31:24] == 8'h00));
  // R7: completion leaves the counter at zero
  a_r7_done_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> (cnt_q == '0));
endmodule

// File: rtl/sdfp_top.sv
module sdfp_top
  import sdfp_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int BSZ_W      = 16,
  parameter int BCNT_W     = 16,
  localparam int CNT_W     = BSZ_W + BCNT_W,
  localparam int LVL_W     = $clog2(FIFO_DEPTH) + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [7:0]  card_rx_data,
  input  logic        card_rx_valid,
  output logic        card_rx_ready,
  output logic [7:0]  card_tx_data,
  output logic        card_tx_valid,
  input  logic        card_tx_ready,
  output logic        xfer_done
);
  logic [15:0]       cmd_q, cmd_d, cfg_q, cfg_d;
  logic [BSZ_W-1:0]  bsz_q, bsz_d;
  logic [BCNT_W-1:0] bcnt_q, bcnt_d;
  logic [2:0]        stat_q, stat_d;   // {block, sdio, data}
  logic [3:0]        fsm_q, fsm_d;
  logic              done_q;
  logic              host_push, host_pop, load;
  logic [CNT_W-1:0]  load_val;
  xfer_mode_e        mode;
  logic              eng_push, eng_pop, ev_data, ev_sdio, ev_block, ev_done;
  logic [31:0]       eng_push_data, fifo_head, push_data;
  logic [LVL_W-1:0]  level;
  logic              fifo_full, fifo_empty;
  logic [31:0]       stat_rd, dbg_rd;

  always_comb begin
    host_push = reg_wr && (reg_addr == OFS_DATA);
    host_pop  = reg_rd && (reg_addr == OFS_DATA);
    load      = reg_wr && (reg_addr == OFS_BCNT);
    load_val  = CNT_W'(bsz_q) * CNT_W'(reg_wdata[BCNT_W-1:0]);
    push_data = host_push ? reg_wdata : eng_push_data;
    if (cmd_q[CMD_RD_BIT])      mode = MODE_RD;
    else if (cmd_q[CMD_WR_BIT]) mode = MODE_WR;
    else                        mode = MODE_IDLE;
  end

  sdfp_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (host_push || eng_push),
    .push_data (push_data),
    .pop       (host_pop || eng_pop),
    .head      (fifo_head),
    .level     (level),
    .full      (fifo_full),
    .empty     (fifo_empty)
  );

  sdfp_engine #(.CNT_W(CNT_W)) u_engine (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode          (mode),
    .cmd_wr        (cmd_q[CMD_WR_BIT]),
    .dint_en       (cfg_q[CFG_DINT_BIT]),
    .bint_en       (cfg_q[CFG_BINT_BIT]),
    .load          (load),
    .load_val      (load_val),
    .host_push     (host_push),
    .host_pop      (host_pop),
    .fifo_full     (fifo_full),
    .fifo_empty    (fifo_empty),
    .fifo_head     (fifo_head),
    .rx_data       (card_rx_data),
    .rx_valid      (card_rx_valid),
    .rx_ready      (card_rx_ready),
    .tx_data       (card_tx_data),
    .tx_valid      (card_tx_valid),
    .tx_ready      (card_tx_ready),
    .eng_push      (eng_push),
    .eng_push_data (eng_push_data),
    .eng_pop       (eng_pop),
    .ev_data       (ev_data),
    .ev_sdio       (ev_sdio),
    .ev_block      (ev_block),
    .ev_done       (ev_done)
  );

  always_comb begin
    cmd_d  = cmd_q;
    cfg_d  = cfg_q;
    bsz_d  = bsz_q;
    bcnt_d = bcnt_q;
    stat_d = stat_q;
    fsm_d  = fsm_q;
    if (reg_wr) begin
      unique case (reg_addr)
        OFS_CMD:  cmd_d  = reg_wdata[15:0] & ~(16'd1 << CMD_LAUNCH_BIT);
        OFS_CFG:  cfg_d  = reg_wdata[15:0];
        OFS_BSZ:  bsz_d  = reg_wdata[BSZ_W-1:0];
        OFS_BCNT: bcnt_d = reg_wdata[BCNT_W-1:0];
        OFS_STAT: stat_d = stat_q & ~{reg_wdata[9], reg_wdata[8], reg_wdata[0]};
        default:  ;
      endcase
    end
    stat_d = stat_d | {ev_block, ev_sdio, ev_data};
    if (ev_done) fsm_d = FSM_DATA;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      cfg_q  <= '0;
      bsz_q  <= '0;
      bcnt_q <= '0;
      stat_q <= '0;
      fsm_q  <= FSM_IDLE;
      done_q <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      cfg_q  <= cfg_d;
      bsz_q  <= bsz_d;
      bcnt_q <= bcnt_d;
      stat_q <= stat_d;
      fsm_q  <= fsm_d;
      done_q <= ev_done;
    end
  end

  always_comb begin
    stat_rd = {22'd0, stat_q[2], stat_q[1], 7'd0, stat_q[0]};
    dbg_rd  = {{(32-LVL_W-4){1'b0}}, level, fsm_q};
    unique case (reg_addr)
      OFS_CMD:  reg_rdata = {16'd0, cmd_q};
      OFS_CFG:  reg_rdata = {16'd0, cfg_q};
      OFS_BSZ:  reg_rdata = 32'(bsz_q);
      OFS_BCNT: reg_rdata = 32'(bcnt_q);
      OFS_STAT: reg_rdata = stat_rd;
      OFS_DBG:  reg_rdata = dbg_rd;
      OFS_DATA: reg_rdata = fifo_head;
      default:  reg_rdata = '0;
    endcase
    xfer_done = done_q;
  end

  // R4: a word movement event leaves the data flag set
  a_r4_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ev_data |=> stat_q[0]);
  // R7: completion switches the debug state field to data mode
  a_r7_fsm: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> (fsm_q == FSM_DATA));
  // R7: the done pulse is never longer than one cycle without a new completion
  a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !ev_done) |=> !xfer_done);
endmodule

// File: tb/sdfp_top_tb.sv
`timescale 1ns/1ps
module sdfp_top_tb;
  logic        clk, rst_n;
  logic        reg_wr, reg_rd;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [7:0]  card_rx_data, card_tx_data;
  logic        card_rx_valid, card_rx_ready, card_tx_valid, card_tx_ready;
  logic        xfer_done;
  int          n_chk, n_err, ngot;
  logic [7:0]  got [64];
  logic        done_seen;
  bit          finished;

  sdfp_top u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .card_rx_data(card_rx_data), .card_rx_valid(card_rx_valid),
    .card_rx_ready(card_rx_ready), .card_tx_data(card_tx_data),
    .card_tx_valid(card_tx_valid), .card_tx_ready(card_tx_ready),
    .xfer_done(xfer_done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) begin
    #2;
    if (rst_n && card_tx_valid && card_tx_ready && ngot < 64) begin
      got[ngot] = card_tx_data;
      ngot++;
    end
    if (rst_n && xfer_done) done_seen = 1'b1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic host_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = (a == 8'h40); reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic feed_byte(input logic [7:0] b);
    @(negedge clk);
    card_rx_valid = 1'b1; card_rx_data = b;
    #1;
    while (!card_rx_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    card_rx_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    host_rd(8'h20, v); chk("R11 status after reset", v, 32'h0);
    host_rd(8'h34, v); chk("R11 debug after reset", v, 32'h0);
    host_rd(8'h40, v); chk("R11 empty fifo pops 0", v, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    host_wr(8'h3C, 32'h0000_1234);
    host_wr(8'h50, 32'h0000_0000);
    host_rd(8'h3C, v); chk("R2 block size readback", v, 32'h1234);
    host_rd(8'h50, v); chk("R2 block count readback", v, 32'h0);
    host_wr(8'h00, 32'h0000_8040);
    host_rd(8'h00, v); chk("R3 command readback drops bit 15", v, 32'h40);
  endtask

  task automatic t_read_pack();
    logic [31:0] v;
    host_wr(8'h20, 32'hFFFF_FFFF);
    host_wr(8'h38, 32'h10);
    host_wr(8'h00, 32'h40);
    host_wr(8'h3C, 32'd6);
    done_seen = 1'b0;
    host_wr(8'h50, 32'd1);
    for (int i = 1; i <= 6; i++) feed_byte(8'(i * 17));
    repeat (3) @(negedge clk);
    chk("R7 done pulse on read", 32'(done_seen), 32'd1);
    host_rd(8'h20, v); chk("R4 data and sdio flags", v, 32'h101);
    host_rd(8'h34, v); chk("R8 R7 debug level 2 data mode", v, 32'h21);
    host_rd(8'h40, v); chk("R3 little-endian word", v, 32'h4433_2211);
    host_rd(8'h40, v); chk("R5 zero padded tail", v, 32'h0000_6655);
    host_wr(8'h20, 32'hFFFF_FFFF);
    host_wr(8'h3C, 32'd3);
    host_wr(8'h50, 32'd1);
    for (int i = 0; i < 3; i++) feed_byte(8'hA0 + 8'(i));
    repeat (2) @(negedge clk);
    host_rd(8'h20, v); chk("R5 partial sets data flag only", v, 32'h001);
    host_rd(8'h40, v); chk("R5 three byte tail", v, 32'h00A2_A1A0);
  endtask

  task automatic t_fifo_limits();
    logic [31:0] v;
    host_wr(8'h00, 32'h0);
    for (int i = 0; i < 17; i++) host_wr(8'h40, 32'hC000_0000 + 32'(i));
    host_rd(8'h34, v); chk("R8 R1 level 16 after overfill", (v >> 4) & 32'h1f, 32'd16);
    for (int i = 0; i < 16; i++) begin
      host_rd(8'h40, v); chk("R10 R1 ring order", v, 32'hC000_0000 + 32'(i));
    end
    host_rd(8'h40, v); chk("R1 extra push dropped, empty pops 0", v, 32'h0);
  endtask

  task automatic t_write_unpack();
    logic [31:0] v;
    host_wr(8'h20, 32'hFFFF_FFFF);
    host_wr(8'h38, 32'h100);
    host_wr(8'h00, 32'h80);
    host_wr(8'h40, 32'h4433_2211);
    host_wr(8'h40, 32'h8877_6655);
    ngot = 0;
    done_seen = 1'b0;
    host_wr(8'h3C, 32'd5);
    host_wr(8'h50, 32'd1);
    repeat (30) @(negedge clk);
    chk("R6 R2 byte count sent", 32'(ngot), 32'd5);
    for (int i = 0; i < 5; i++) chk("R6 lsb-first byte", 32'(got[i]), 32'h11 * 32'(i + 1));
    chk("R7 done pulse on write", 32'(done_seen), 32'd1);
    host_rd(8'h20, v); chk("R7 block flag on write", v, 32'h201);
    host_rd(8'h34, v); chk("R8 debug after write", v, 32'h001);
    host_wr(8'h20, 32'h200);
    host_rd(8'h20, v); chk("R9 selective clear", v, 32'h001);
  endtask

  task automatic t_read_stall();
    logic [31:0] v;
    host_wr(8'h38, 32'h0);
    host_wr(8'h00, 32'h40);
    host_wr(8'h3C, 32'd68);
    host_wr(8'h50, 32'd1);
    for (int i = 0; i < 64; i++) feed_byte(8'(i));
    @(negedge clk);
    card_rx_valid = 1'b1; card_rx_data = 8'hEE;
    #1 chk("R3 no take when fifo full", 32'(card_rx_ready), 32'd0);
    host_wr(8'h50, 32'd0);
    host_rd(8'h40, v); chk("R3 first packed word", v, 32'h0302_0100);
    @(negedge clk); #1;
    chk("R3 no take when count zero", 32'(card_rx_ready), 32'd0);
    card_rx_valid = 1'b0;
    for (int i = 1; i < 16; i++) host_rd(8'h40, v);
    host_rd(8'h34, v); chk("R8 drained level", (v >> 4) & 32'h1f, 32'd0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    n_chk = 0; n_err = 0; ngot = 0; done_seen = 1'b0; finished = 1'b0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = 8'h0; reg_wdata = '0;
    card_rx_data = '0; card_rx_valid = 1'b0; card_tx_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_read_pack();
    t_fifo_limits();
    t_write_unpack();
    t_read_stall();
    repeat (2) @(negedge clk);
    summary();
  end
endmodule